// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is a circular reorder buffer for a speculative out-of-order core. An instruction is placed in the buffer when it issues. It can issue only if a slot is free and the outside scheduler reports a free reservation station. The index of the slot it gets is returned as the rename tag for its destination. Functional units later broadcast results on a shared result bus. When the tag on the bus matches a live slot, that slot takes the value and is marked complete.

Retirement takes place only at the oldest slot, and only after that slot's result has arrived. Retiring a register instruction writes the architectural register file. Retiring a store signals the store unit and hands it the data. Retiring a branch normally has no side effect. If the retiring branch was mispredicted, every younger entry is discarded in a single cycle and a one-cycle flush pulse is sent out so that tag state held outside the buffer can be cleared.

Top module: `rob_core`

## Requirements
- R1: While rst is high, and in the cycle after it falls, the buffer is empty and not full, iss_tag is 0, and cmt_valid, cmt_reg_we, cmt_store and flush_pulse are 0.
- R2: An issue is accepted only when iss_valid and iss_rs_free are both 1 and the buffer is not full. Each accepted issue takes the slot shown on iss_tag, and iss_tag then advances by one modulo DEPTH. When iss_rs_free is 0, the request changes nothing.
- R3: After DEPTH accepted issues with no retirement, rob_full is 1. A further issue request is ignored: iss_tag does not change and no extra entry is ever retired. rob_full and rob_empty are never 1 together.
- R4: A result with res_valid=1 whose res_tag names a live slot stores res_value and res_mispredict in that slot and marks it complete. A result for a slot that is not live, including the slot being allocated in that same cycle, is ignored.
- R5: Only the oldest live entry can retire, and only once its result is present. A younger entry whose result arrives first waits until every older entry has retired. Entries retire in issue order, at most one per cycle, and never while the buffer is empty.
- R6: When an entry retires at a clock edge, the commit outputs are registered and hold for the following cycle: cmt_valid=1, cmt_dst and cmt_value show the entry's destination and result, and in cycles with no retirement all four commit outputs are 0.
- R7: When the retiring entry is a branch with its mispredict flag set, it retires and all younger entries are discarded. Any issue request in that cycle is dropped. In the next cycle flush_pulse is 1 for exactly one cycle, the buffer is empty, and iss_tag equals the slot just after the retired branch.
- R8: One issue and one retirement can take place in the same cycle.
- R9: iss_kind encodes 0 = register write, 1 = store, 2 = branch. On retirement, cmt_reg_we is 1 only for kind 0, cmt_store is 1 only for kind 1, and both are 0 for a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_rs_free | input | 1 | A reservation station is free for this issue |
| iss_kind | input | 2 | Entry kind: 0 register, 1 store, 2 branch |
| iss_dst | input | REG_W | Destination register number |
| iss_tag | output | $clog2(DEPTH) | Slot assigned to the next accepted issue (rename tag) |
| rob_full | output | 1 | No free slot |
| rob_empty | output | 1 | No live entry |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| res_value | input | DATA_W | Result value (store data for stores) |
| res_mispredict | input | 1 | The branch in this slot was mispredicted |
| cmt_valid | output | 1 | An entry retired at the last edge |
| cmt_reg_we | output | 1 | Write cmt_value to register cmt_dst |
| cmt_store | output | 1 | Perform the store with data cmt_value |
| cmt_dst | output | REG_W | Destination register of the retired entry |
| cmt_value | output | DATA_W | Result of the retired entry |
| flush_pulse | output | 1 | One-cycle pulse after a mispredict flush |

## Verification
The properties check on every cycle that the tag steps by one modulo the depth or holds, that full and empty never both assert, that no retirement follows an empty buffer, that at most one of the register-write and store strobes fires and only alongside cmt_valid, that a flush lasts one cycle and leaves the buffer empty, and the reset state. Issue order, the wait of a younger completed entry behind an incomplete head, the values and destinations carried to the commit port, dropping a result aimed at a slot that is just being allocated, and the discard of a completed younger entry on a mispredict can only be shown by the bench's scenarios, which follow whole instruction sequences from issue to retirement.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr.sv
// Circular pointer: slot index plus one wrap bit, so that equal indices
// can be told apart as empty (same wrap) or full (different wrap).
module rob_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr_q
);
  logic [IDX_W-1:0] idx;
  logic             wrap;

  assign idx  = ptr_q[IDX_W-1:0];
  assign wrap = ptr_q[IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_val;
    end else if (adv) begin
      if (idx == IDX_W'(DEPTH - 1)) ptr_q <= {~wrap, {IDX_W{1'b0}}};
      else                          ptr_q <= {wrap, idx + 1'b1};
    end
  end
endmodule

// File: rtl/rob_table.sv
// Entry storage. Status bits live in flops; kind, destination and value
// sit in arrays with one write port each so they can map to RAM.
module rob_table
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_val,
  input  logic              wb_mp,
  input  logic              rel_en,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic              clr_all,
  input  logic [IDX_W-1:0]  hd_idx,
  output logic              hd_live,
  output logic              hd_done,
  output logic              hd_mp,
  output rob_kind_e         hd_kind,
  output logic [REG_W-1:0]  hd_dst,
  output logic [DATA_W-1:0] hd_value
);
  logic [DEPTH-1:0]  live;
  logic [DEPTH-1:0]  done;
  logic [DEPTH-1:0]  mp;
  rob_kind_e         kind_mem [DEPTH];
  logic [REG_W-1:0]  dst_mem  [DEPTH];
  logic [DATA_W-1:0] val_mem  [DEPTH];
  logic              wb_ok;

  // a result counts only for a slot that was live before this edge
  assign wb_ok = wb_en & live[wb_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      done <= '0;
      mp   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (clr_all) begin
          live[i] <= 1'b0;
        end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
          live[i] <= 1'b1;
          done[i] <= 1'b0;
          mp[i]   <= 1'b0;
        end else if (rel_en && rel_idx == IDX_W'(i)) begin
          live[i] <= 1'b0;
        end else if (wb_ok && wb_idx == IDX_W'(i)) begin
          done[i] <= 1'b1;
          mp[i]   <= wb_mp;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      kind_mem[alloc_idx] <= alloc_kind;
      dst_mem[alloc_idx]  <= alloc_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_ok) val_mem[wb_idx] <= wb_val;
  end

  assign hd_live  = live[hd_idx];
  assign hd_done  = done[hd_idx];
  assign hd_mp    = mp[hd_idx];
  assign hd_kind  = kind_mem[hd_idx];
  assign hd_dst   = dst_mem[hd_idx];
  assign hd_value = val_mem[hd_idx];
endmodule

// File: rtl/rob_retire.sv
// Retirement decision on the head entry and the registered commit port.
module rob_retire
  import rob_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hd_live,
  input  logic              hd_done,
  input  logic              hd_mp,
  input  rob_kind_e         hd_kind,
  input  logic [REG_W-1:0]  hd_dst,
  input  logic [DATA_W-1:0] hd_value,
  output logic              fire,
  output logic              squash,
  output logic              cmt_valid,
  output logic              cmt_reg_we,
  output logic              cmt_store,
  output logic [REG_W-1:0]  cmt_dst,
  output logic [DATA_W-1:0] cmt_value,
  output logic              flush_pulse
);
  assign fire   = hd_live & hd_done;
  assign squash = fire & (hd_kind == KIND_BRANCH) & hd_mp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid   <= 1'b0;
      cmt_reg_we  <= 1'b0;
      cmt_store   <= 1'b0;
      cmt_dst     <= '0;
      cmt_value   <= '0;
      flush_pulse <= 1'b0;
    end else begin
      cmt_valid   <= fire;
      cmt_reg_we  <= fire & (hd_kind == KIND_REG);
      cmt_store   <= fire & (hd_kind == KIND_STORE);
      cmt_dst     <= fire ? hd_dst   : '0;
      cmt_value   <= fire ? hd_value : '0;
      flush_pulse <= squash;
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic              iss_rs_free,
  input  logic [1:0]        iss_kind,
  input  logic [REG_W-1:0]  iss_dst,
  output logic [IDX_W-1:0]  iss_tag,
  output logic              rob_full,
  output logic              rob_empty,
  input  logic              res_valid,
  input  logic [IDX_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_mispredict,
  output logic              cmt_valid,
  output logic              cmt_reg_we,
  output logic              cmt_store,
  output logic [REG_W-1:0]  cmt_dst,
  output logic [DATA_W-1:0] cmt_value,
  output logic              flush_pulse
);
  logic [PTR_W-1:0]  head_q, tail_q, head_nx;
  logic              alloc_go, fire, squash;
  logic              hd_live, hd_done, hd_mp;
  rob_kind_e         hd_kind;
  logic [REG_W-1:0]  hd_dst;
  logic [DATA_W-1:0] hd_value;

  assign rob_empty = (head_q == tail_q);
  assign rob_full  = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                     (head_q[IDX_W] != tail_q[IDX_W]);
  assign iss_tag   = tail_q[IDX_W-1:0];
  // a flush drops the issue in the same cycle: that entry would be younger
  assign alloc_go  = iss_valid & iss_rs_free & ~rob_full & ~squash;

  // slot after the head, where the tail lands on a flush
  always_comb begin
    if (head_q[IDX_W-1:0] == IDX_W'(DEPTH - 1))
      head_nx = {~head_q[IDX_W], {IDX_W{1'b0}}};
    else
      head_nx = {head_q[IDX_W], head_q[IDX_W-1:0] + 1'b1};
  end

  rob_ptr #(.DEPTH(DEPTH)) u_head (
    .clk(clk), .rst(rst), .adv(fire), .load(1'b0), .load_val('0),
    .ptr_q(head_q)
  );

  rob_ptr #(.DEPTH(DEPTH)) u_tail (
    .clk(clk), .rst(rst), .adv(alloc_go), .load(squash), .load_val(head_nx),
    .ptr_q(tail_q)
  );

  rob_table #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_tab (
    .clk(clk), .rst(rst),
    .alloc_en(alloc_go), .alloc_idx(tail_q[IDX_W-1:0]),
    .alloc_kind(rob_kind_e'(iss_kind)), .alloc_dst(iss_dst),
    .wb_en(res_valid), .wb_idx(res_tag), .wb_val(res_value), .wb_mp(res_mispredict),
    .rel_en(fire), .rel_idx(head_q[IDX_W-1:0]), .clr_all(squash),
    .hd_idx(head_q[IDX_W-1:0]),
    .hd_live(hd_live), .hd_done(hd_done), .hd_mp(hd_mp), .hd_kind(hd_kind),
    .hd_dst(hd_dst), .hd_value(hd_value)
  );

  rob_retire #(.REG_W(REG_W), .DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst(rst),
    .hd_live(hd_live), .hd_done(hd_done), .hd_mp(hd_mp), .hd_kind(hd_kind),
    .hd_dst(hd_dst), .hd_value(hd_value),
    .fire(fire), .squash(squash),
    .cmt_valid(cmt_valid), .cmt_reg_we(cmt_reg_we), .cmt_store(cmt_store),
    .cmt_dst(cmt_dst), .cmt_value(cmt_value), .flush_pulse(flush_pulse)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_rs_free,
  input logic [IDX_W-1:0] iss_tag,
  input logic             rob_full,
  input logic             rob_empty,
  input logic             cmt_valid,
  input logic             cmt_reg_we,
  input logic             cmt_store,
  input logic             flush_pulse
);
  logic [IDX_W-1:0] tag_step;
  assign tag_step = (iss_tag == IDX_W'(DEPTH - 1)) ? '0 : iss_tag + 1'b1;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rob_empty && !rob_full && iss_tag == '0 && !cmt_valid &&
             !cmt_reg_we && !cmt_store && !flush_pulse));

  a_r2_tag_advance: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_rs_free && !rob_full) |=>
      (flush_pulse || iss_tag == $past(tag_step)));

  a_r2_tag_hold: assert property (@(posedge clk) disable iff (rst)
    !(iss_valid && iss_rs_free) |=> (flush_pulse || $stable(iss_tag)));

  a_r3_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
    !(rob_full && rob_empty));

  a_r5_no_retire_empty: assert property (@(posedge clk) disable iff (rst)
    cmt_valid |-> $past(!rob_empty));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmt_reg_we, cmt_store}) && ((cmt_reg_we || cmt_store) -> cmt_valid));

  a_r7_flush_single: assert property (@(posedge clk) disable iff (rst)
    flush_pulse |=> !flush_pulse);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_pulse |-> (rob_empty && cmt_valid && !cmt_reg_we && !cmt_store));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_rs_free(iss_rs_free),
  .iss_tag(iss_tag), .rob_full(rob_full), .rob_empty(rob_empty),
  .cmt_valid(cmt_valid), .cmt_reg_we(cmt_reg_we), .cmt_store(cmt_store),
  .flush_pulse(flush_pulse)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;
  localparam int DEPTH  = 8;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int NROWS  = 22;

  // columns: stimulus, then expected state after the edge
  localparam int C_IV = 0, C_IK = 1, C_ID = 2, C_RS = 3, C_CV = 4, C_CT = 5,
                 C_CVAL = 6, C_CMP = 7, E_TAG = 8, E_CV = 9, E_WE = 10,
                 E_ST = 11, E_DST = 12, E_VAL = 13, E_FL = 14, E_EM = 15, E_FU = 16;

  localparam int TBL [NROWS][17] = '{
    '{1,0, 3,1, 0,0,   0,0, 1,0,0,0, 0,   0,0,0,0},  // reg -> slot 0
    '{1,1, 0,1, 1,0,'h11,0, 2,0,0,0, 0,   0,0,0,0},  // store -> slot 1, result slot 0
    '{1,2, 0,1, 1,1,'h22,0, 3,1,1,0, 3,'h11,0,0,0},  // R8: issue and retire together
    '{0,0, 0,1, 1,2,   0,0, 3,1,0,1, 0,'h22,0,0,0},  // store retires (R9)
    '{0,0, 0,1, 0,0,   0,0, 3,1,0,0, 0,   0,0,1,0},  // branch retires, no strobes
    '{1,0, 7,1, 0,0,   0,0, 4,0,0,0, 0,   0,0,0,0},
    '{1,0, 8,1, 1,4,'h99,0, 5,0,0,0, 0,   0,0,0,0},  // R4: result to slot being allocated
    '{0,0, 0,1, 1,4,'h44,0, 5,0,0,0, 0,   0,0,0,0},  // younger completes first
    '{0,0, 0,1, 0,0,   0,0, 5,0,0,0, 0,   0,0,0,0},  // R5: head not done, no retire
    '{0,0, 0,1, 1,3,'h33,0, 5,0,0,0, 0,   0,0,0,0},
    '{0,0, 0,1, 0,0,   0,0, 5,1,1,0, 7,'h33,0,0,0},
    '{0,0, 0,1, 0,0,   0,0, 5,1,1,0, 8,'h44,0,1,0},
    '{1,2, 0,1, 0,0,   0,0, 6,0,0,0, 0,   0,0,0,0},  // branch -> slot 5
    '{1,0,10,1, 0,0,   0,0, 7,0,0,0, 0,   0,0,0,0},
    '{1,0,11,1, 1,6,'h66,0, 0,0,0,0, 0,   0,0,0,0},  // tag wraps to 0
    '{0,0, 0,1, 1,5,   0,1, 0,0,0,0, 0,   0,0,0,0},  // branch mispredicted
    '{1,0,12,1, 0,0,   0,0, 6,1,0,0, 0,   0,1,1,0},  // R7: flush, issue dropped
    '{0,0, 0,1, 0,0,   0,0, 6,0,0,0, 0,   0,0,1,0},  // completed slot 6 discarded
    '{1,0,13,1, 0,0,   0,0, 7,0,0,0, 0,   0,0,0,0},
    '{0,0, 0,1, 1,6,'h77,0, 7,0,0,0, 0,   0,0,0,0},
    '{0,0, 0,1, 0,0,   0,0, 7,1,1,0,13,'h77,0,1,0},
    '{1,0,14,0, 0,0,   0,0, 7,0,0,0, 0,   0,0,1,0}   // no station free: ignored
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0, iss_rs_free = 1'b0;
  logic [1:0] iss_kind = '0;
  logic [REG_W-1:0] iss_dst = '0;
  logic [IDX_W-1:0] iss_tag;
  logic rob_full, rob_empty;
  logic res_valid = 1'b0;
  logic [IDX_W-1:0] res_tag = '0;
  logic [DATA_W-1:0] res_value = '0;
  logic res_mispredict = 1'b0;
  logic cmt_valid, cmt_reg_we, cmt_store, flush_pulse;
  logic [REG_W-1:0] cmt_dst;
  logic [DATA_W-1:0] cmt_value;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_rs_free(iss_rs_free),
    .iss_kind(iss_kind), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .rob_full(rob_full), .rob_empty(rob_empty), .res_valid(res_valid),
    .res_tag(res_tag), .res_value(res_value), .res_mispredict(res_mispredict),
    .cmt_valid(cmt_valid), .cmt_reg_we(cmt_reg_we), .cmt_store(cmt_store),
    .cmt_dst(cmt_dst), .cmt_value(cmt_value), .flush_pulse(flush_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    iss_valid = 1'b0; iss_rs_free = 1'b1; iss_kind = '0; iss_dst = '0;
    res_valid = 1'b0; res_tag = '0; res_value = '0; res_mispredict = 1'b0;
  endtask

  task automatic chk_reset(input string tag);
    chk({tag, " R1 empty"}, int'(rob_empty), 1);
    chk({tag, " R1 full"}, int'(rob_full), 0);
    chk({tag, " R1 tag"}, int'(iss_tag), 0);
    chk({tag, " R1 commit"}, int'({cmt_valid, cmt_reg_we, cmt_store, flush_pulse}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_run++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int commits;
    idle_inputs();
    rst = 1'b1;
    repeat (3) step();
    chk_reset("in reset");
    rst = 1'b0;
    step();
    chk_reset("after reset");

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      iss_valid      = TBL[r][C_IV] != 0;
      iss_kind       = 2'(TBL[r][C_IK]);
      iss_dst        = REG_W'(TBL[r][C_ID]);
      iss_rs_free    = TBL[r][C_RS] != 0;
      res_valid      = TBL[r][C_CV] != 0;
      res_tag        = IDX_W'(TBL[r][C_CT]);
      res_value      = DATA_W'(TBL[r][C_CVAL]);
      res_mispredict = TBL[r][C_CMP] != 0;
      step();
      chk($sformatf("row %0d R2 tag", r), int'(iss_tag), TBL[r][E_TAG]);
      chk($sformatf("row %0d R5 retire", r), int'(cmt_valid), TBL[r][E_CV]);
      chk($sformatf("row %0d R9 reg strobe", r), int'(cmt_reg_we), TBL[r][E_WE]);
      chk($sformatf("row %0d R9 store strobe", r), int'(cmt_store), TBL[r][E_ST]);
      chk($sformatf("row %0d R6 dst", r), int'(cmt_dst), TBL[r][E_DST]);
      chk($sformatf("row %0d R4 R6 value", r), int'(cmt_value), TBL[r][E_VAL]);
      chk($sformatf("row %0d R7 flush", r), int'(flush_pulse), TBL[r][E_FL]);
      chk($sformatf("row %0d R3 empty", r), int'(rob_empty), TBL[r][E_EM]);
      chk($sformatf("row %0d R3 full", r), int'(rob_full), TBL[r][E_FU]);
    end
    idle_inputs();

    // fill from slot 7 until full, then one extra request (R3)
    for (int k = 0; k < DEPTH; k++) begin
      iss_valid = 1'b1; iss_kind = 2'd0; iss_dst = REG_W'(20 + k);
      step();
    end
    chk("R3 full after DEPTH issues", int'(rob_full), 1);
    chk("R3 tag wrapped", int'(iss_tag), 7);
    iss_dst = REG_W'(31);
    step();
    chk("R3 issue while full ignored", int'(iss_tag), 7);
    chk("R3 still full", int'(rob_full), 1);
    idle_inputs();

    // results youngest first; nothing may retire before the oldest completes
    commits = 0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      res_valid = 1'b1;
      res_tag   = IDX_W'((7 + k) % DEPTH);
      res_value = DATA_W'(32'h100 + k);
      step();
      if (cmt_valid) commits++;
    end
    idle_inputs();
    chk("R5 no retire before head done", commits, 0);
    for (int c = 0; c < 12; c++) begin
      step();
      if (cmt_valid) begin
        chk("R5 retire order dst", int'(cmt_dst), 20 + commits);
        chk("R6 retire value", int'(cmt_value), 32'h100 + commits);
        commits++;
      end
    end
    chk("R3 exactly DEPTH retired", commits, DEPTH);
    chk("R3 empty after drain", int'(rob_empty), 1);

    // reset in mid-run
    iss_valid = 1'b1; iss_dst = REG_W'(5);
    step();
    step();
    idle_inputs();
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    chk_reset("mid-run reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule